// File: doc/BRIEF.md
# Single-Channel DMA Controller

This block moves words between one peripheral and memory while the processor has given up the system bus. The processor programs a start address, a word count and a control word through a small register port. A control write with the enable bit set and a nonzero count arms the channel. From then on the peripheral's request level drives the work. When the peripheral asks for service, the controller requests the bus. Once the processor grants it, the controller drives the memory address and one strobe for exactly one cycle per word and acknowledges the peripheral in that same cycle.

The data word travels on the shared data bus directly between the peripheral and memory. The controller supplies only the address, the strobe and the timing. If the peripheral has no further request when a word completes, the controller hands the bus back at once. It asks again only after the grant has fallen and the request returns. When the last word has moved, the controller releases the bus, disarms itself and raises a done flag that the processor can read.

Top module: `dma_chan`

## Requirements
- R1: After a synchronous reset, bus_req, per_ack, mem_rd, mem_wr and mem_oe are low, dout is zero, and the address, count and control registers read back as zero.
- R2: With cs high and bus_grant low, rd or wr accesses the register chosen by rs. rs=0 selects the address register and rs=1 the word count. rs=2 selects control, where bit0 is enable/armed, bit1 is direction and bit2 is done (read only). rs=3 reads as zero. Read data appears on dout one clock edge after the read strobe is sampled.
- R3: Register writes made while bus_grant is high have no effect.
- R4: Writing control with bit0=1 arms the channel only when the count is nonzero. With a zero count, nothing is requested or transferred, and bit0 reads back as 0.
- R5: An armed channel that samples per_req high while bus_grant is low raises bus_req on the next edge.
- R6: A word moves in the cycle that follows the edge at which the controller sees bus_grant while it is requesting. In that single cycle per_ack and mem_oe are high and mem_addr equals the address register. Direction 1 (peripheral to memory) asserts mem_wr and direction 0 (memory to peripheral) asserts mem_rd.
- R7: Each moved word increments the address register by one and decrements the count by one.
- R8: When per_req is high at the end of a word that is not the last, the next word moves in the very next cycle, and bus_req stays high throughout.
- R9: When per_req is low at the end of a word that is not the last, bus_req falls on that edge. It rises again only when per_req is high and bus_grant has fallen.
- R10: After the last word, bus_req falls, done reads 1 and enable reads 0. Re-arming clears done.
- R11: Writing control with bit0=0 while the channel is armed and not yet granted disarms it, and later peripheral requests are ignored.
- R12: per_ack, mem_oe, mem_rd and mem_wr are never high while bus_grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register port select |
| rs | input | 2 | Register index |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| din | input | DW | Register write data |
| dout | output | DW | Registered read data |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Processor has released the bus |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Peripheral acknowledge, one cycle per word |
| mem_addr | output | AW | Memory address while a word moves |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_oe | output | 1 | Enable for the memory-side address and strobes |

## Verification
A fast peripheral that holds its request high through a whole block tests back-to-back transfers. It shows that the words move on consecutive cycles under a single bus tenure, rather than with the bus released between them. A slow peripheral that raises its request once per word and drops it right after the acknowledge checks bus release and re-request. It separates a controller that returns the bus between words from one that keeps holding it, and it confirms the address seen by memory in each direction. A zero count at arm time, a cancel before grant, and writes attempted while a grant is forced high show whether arming and register access are properly gated.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_XFER = 2'd3
  } dma_st_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTL_EN   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_DONE = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic [1:0]    rs,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] din,
  input  logic          grant,
  input  logic          step,
  input  logic          armed,
  output logic [DW-1:0] dout,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          done_q,
  output logic          cnt_last,
  output logic          arm,
  output logic          disarm
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          acc_ok;
  logic          wr_en;
  logic          rd_en;
  logic          ctl_wr;
  logic [DW-1:0] rd_mux;

  assign acc_ok   = cs && !grant;
  assign wr_en    = acc_ok && wr;
  assign rd_en    = acc_ok && rd;
  assign ctl_wr   = wr_en && (rs == SEL_CTRL);
  assign cnt_last = (cnt_q == CNT_ONE);
  assign arm      = ctl_wr && din[CTL_EN] && (cnt_q != '0);
  assign disarm   = ctl_wr && !din[CTL_EN];

  always_comb begin
    rd_mux = '0;
    case (rs)
      SEL_ADDR: rd_mux = DW'(addr_q);
      SEL_CNT:  rd_mux = DW'(cnt_q);
      SEL_CTRL: begin
        rd_mux[CTL_EN]   = armed;
        rd_mux[CTL_DIR]  = dir_q;
        rd_mux[CTL_DONE] = done_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      dout   <= '0;
    end else begin
      if (wr_en && rs == SEL_ADDR)     addr_q <= din[AW-1:0];
      else if (step)                   addr_q <= addr_q + 1'b1;

      if (wr_en && rs == SEL_CNT)      cnt_q <= din[CW-1:0];
      else if (step)                   cnt_q <= cnt_q - 1'b1;

      if (ctl_wr)                      dir_q <= din[CTL_DIR];

      if (arm)                         done_q <= 1'b0;
      else if (step && cnt_last)       done_q <= 1'b1;

      if (rd_en)                       dout <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    arm,
  input  logic    disarm,
  input  logic    per_req,
  input  logic    grant,
  input  logic    cnt_last,
  output dma_st_e state,
  output logic    armed,
  output logic    bus_req,
  output logic    xfer
);
  dma_st_e state_n;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE: if (arm) state_n = ST_WAIT;
      ST_WAIT: begin
        if (disarm)                 state_n = ST_IDLE;
        else if (per_req && !grant) state_n = ST_REQ;
      end
      ST_REQ: begin
        if (grant)       state_n = ST_XFER;
        else if (disarm) state_n = ST_IDLE;
      end
      ST_XFER: begin
        if (cnt_last)              state_n = ST_IDLE;
        else if (per_req && grant) state_n = ST_XFER;
        else                       state_n = ST_WAIT;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_n;
  end

  assign armed   = (state != ST_IDLE);
  assign bus_req = (state == ST_REQ) || (state == ST_XFER);
  assign xfer    = (state == ST_XFER);
endmodule

// File: rtl/dma_mem_port.sv
module dma_mem_port #(
  parameter int AW = 16
) (
  input  logic          xfer,
  input  logic          grant,
  input  logic          dir,
  input  logic [AW-1:0] addr,
  output logic          step,
  output logic          oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr
);
  assign oe       = xfer && grant;
  assign step     = oe;
  assign mem_addr = oe ? addr : '0;
  assign mem_rd   = oe && !dir;
  assign mem_wr   = oe && dir;
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic [1:0]    rs,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          per_req,
  output logic          per_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_oe
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q;
  logic          done_q;
  logic          cnt_last;
  logic          arm;
  logic          disarm;
  logic          armed;
  logic          xfer;
  logic          step;
  dma_st_e       state;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cs(cs), .rs(rs), .rd(rd), .wr(wr), .din(din),
    .grant(bus_grant), .step(step), .armed(armed), .dout(dout),
    .addr_q(addr_q), .cnt_q(cnt_q), .dir_q(dir_q), .done_q(done_q),
    .cnt_last(cnt_last), .arm(arm), .disarm(disarm)
  );

  dma_fsm u_fsm (
    .clk(clk), .rst(rst), .arm(arm), .disarm(disarm), .per_req(per_req),
    .grant(bus_grant), .cnt_last(cnt_last), .state(state), .armed(armed),
    .bus_req(bus_req), .xfer(xfer)
  );

  dma_mem_port #(.AW(AW)) u_mem (
    .xfer(xfer), .grant(bus_grant), .dir(dir_q), .addr(addr_q),
    .step(step), .oe(mem_oe), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  assign per_ack = mem_oe;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          per_req,
  input logic          per_ack,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_oe,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q,
  input logic          done_q
);
  AST_ACK_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> (bus_grant && bus_req && mem_oe)); // R12
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}) && ((mem_rd || mem_wr) == per_ack)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    per_ack ##1 per_ack |-> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    per_ack |=> (cnt_q == CW'($past(cnt_q) - 1'b1))); // R7
  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && !per_ack) |=> ($stable(addr_q) && $stable(cnt_q))); // R3
  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (rst)
    (per_ack && cnt_q == CW'(1)) |=> (!bus_req && done_q)); // R10
  AST_REQ_NEEDS_PERIPH: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(per_req && !bus_grant)); // R5
  AST_DROP_NO_PERIPH: assert property (@(posedge clk) disable iff (rst)
    (per_ack && !per_req && cnt_q != CW'(1)) |=> !bus_req); // R9
endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_grant(bus_grant),
  .per_req(per_req), .per_ack(per_ack), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_oe(mem_oe), .mem_addr(mem_addr), .addr_q(addr_q), .cnt_q(cnt_q),
  .done_q(done_q)
);

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]    rs = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          bus_req, bus_grant = 1'b0, grant_hold = 1'b0;
  logic          per_req = 1'b0, per_ack;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, mem_oe;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int first_ack = -1;
  int last_ack = -1;
  logic [AW:0] expq[$];

  dma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_dma_chan (
    .clk(clk), .rst(rst), .cs(cs), .rs(rs), .rd(rd), .wr(wr), .din(din),
    .dout(dout), .bus_req(bus_req), .bus_grant(bus_grant), .per_req(per_req),
    .per_ack(per_ack), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_oe(mem_oe)
  );

  always #10 clk = ~clk;

  // processor model: grant follows request one edge later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) bus_grant <= 1'b0;
    else     bus_grant <= bus_req | grant_hold;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word per acknowledge
  always @(negedge clk) begin
    if (!rst && per_ack) begin
      if (first_ack < 0) first_ack = cyc;
      last_ack = cyc;
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected transfer", mem_addr, 0);
      end else begin
        logic [AW:0] e;
        e = expq.pop_front();
        chk(mem_addr == e[AW-1:0], "R6 address", mem_addr, e[AW-1:0]);
        chk(mem_wr == e[AW] && mem_rd == !e[AW], "R6 strobe",
            {mem_wr, mem_rd}, {e[AW], !e[AW]});
        chk(mem_oe && bus_grant, "R12 oe with grant", {mem_oe, bus_grant}, 3);
      end
    end
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [DW-1:0] v);
    @(negedge clk);
    cs = 1; wr = 1; rs = sel; din = v;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    cs = 1; rd = 1; rs = sel;
    @(negedge clk);
    cs = 0; rd = 0;
    chk(dout == exp, tag, dout, exp);
  endtask

  task automatic push_block(input logic [AW-1:0] a, input int n, input logic dir);
    for (int i = 0; i < n; i++) expq.push_back({dir, AW'(a + AW'(i))});
  endtask

  task automatic wait_drain();
    int g = 0;
    while (expq.size() != 0 && g < 1000) begin
      @(posedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk({bus_req, per_ack, mem_rd, mem_wr, mem_oe} == 0, "R1 outputs", {bus_req, per_ack, mem_rd, mem_wr, mem_oe}, 0);
    chk(dout == 0, "R1 dout", dout, 0);
    reg_rd(2'd0, 16'h0, "R1 addr reset");
    reg_rd(2'd1, 16'h0, "R1 count reset");
    reg_rd(2'd2, 16'h0, "R1 ctrl reset");

    // R2 register access
    reg_wr(2'd0, 16'h1234);
    reg_rd(2'd0, 16'h1234, "R2 addr rw");
    reg_wr(2'd1, 16'h0007);
    reg_rd(2'd1, 16'h0007, "R2 count rw");
    reg_rd(2'd3, 16'h0000, "R2 rs3 zero");

    // R3 writes ignored under grant
    grant_hold = 1;
    repeat (2) @(negedge clk);
    reg_wr(2'd0, 16'hBEEF);
    reg_wr(2'd1, 16'h0055);
    chk(mem_oe == 0 && per_ack == 0, "R12 idle under grant", {mem_oe, per_ack}, 0);
    grant_hold = 0;
    repeat (2) @(negedge clk);
    reg_rd(2'd0, 16'h1234, "R3 addr unchanged");
    reg_rd(2'd1, 16'h0007, "R3 count unchanged");

    // R4 zero count does not arm
    reg_wr(2'd1, 16'h0000);
    reg_wr(2'd2, 16'h0001);
    per_req = 1;
    repeat (5) @(negedge clk);
    chk(bus_req == 0, "R4 no request", bus_req, 0);
    per_req = 0;
    reg_rd(2'd2, 16'h0000, "R4 enable stays 0");

    // burst, peripheral to memory: R6 R7 R8 R10
    reg_wr(2'd0, 16'h0100);
    reg_wr(2'd1, 16'h0004);
    push_block(16'h0100, 4, 1'b1);
    first_ack = -1; last_ack = -1;
    reg_wr(2'd2, 16'h0003);
    per_req = 1;
    wait_drain();
    chk(last_ack - first_ack == 3, "R8 back-to-back words", last_ack - first_ack, 3);
    chk(bus_req == 0, "R10 release after last", bus_req, 0);
    per_req = 0;
    repeat (3) @(negedge clk);
    reg_rd(2'd0, 16'h0104, "R7 address advanced");
    reg_rd(2'd1, 16'h0000, "R7 count to zero");
    reg_rd(2'd2, 16'h0006, "R10 done set, disarmed");

    // slow peripheral, memory to peripheral: R5 R6 R9 R10
    reg_wr(2'd0, 16'h0200);
    reg_wr(2'd1, 16'h0003);
    push_block(16'h0200, 3, 1'b0);
    reg_wr(2'd2, 16'h0001);
    reg_rd(2'd2, 16'h0001, "R10 rearm clears done");
    for (int w = 0; w < 3; w++) begin
      per_req = 1;
      @(negedge clk);
      chk(bus_req == 1, "R5 request raised", bus_req, 1);
      @(negedge clk);
      chk(per_ack == 0, "R6 no ack before grant seen", per_ack, 0);
      @(negedge clk);
      chk(per_ack == 1, "R6 ack after grant", per_ack, 1);
      per_req = 0;
      @(negedge clk);
      chk(bus_req == 0, "R9 bus released", bus_req, 0);
      repeat (3) @(negedge clk);
      chk(bus_req == 0 && per_ack == 0, "R9 stays released", {bus_req, per_ack}, 0);
    end
    reg_rd(2'd0, 16'h0203, "R7 slow address");
    reg_rd(2'd2, 16'h0004, "R10 slow done");

    // R11 cancel before grant
    reg_wr(2'd1, 16'h0002);
    reg_wr(2'd2, 16'h0001);
    reg_wr(2'd2, 16'h0000);
    reg_rd(2'd2, 16'h0000, "R11 disarmed");
    per_req = 1;
    repeat (4) @(negedge clk);
    chk(bus_req == 0, "R11 request ignored", bus_req, 0);
    per_req = 0;
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R6 all words seen", expq.size(), 0);
    finish_run();
  end
endmodule